// File: doc/BRIEF.md
# Operand Effective Address Generator

This block computes the effective address of a memory operand for an 8-bit accumulator processor. The processor has two 8-bit index registers and a 16-bit address bus. The sequencer presents the addressing mode and the operand bytes that follow the opcode. It also presents both index registers, the pointer bytes it has already fetched and whether the access is a read or a store / read-modify-write. It then raises `req` for one clock. One clock later the block returns the effective address, the advanced program counter and a page-crossing flag. It also returns a one-clock request for an extra dummy bus cycle when the mode costs one.

Pointer-based modes need two bytes from memory before the effective address exists. For these modes the block drives the two pointer fetch addresses combinationally from the mode, the operand bytes and the X register, so the sequencer can issue those reads first. Zero-page indexing and zero-page pointer fetches stay inside page zero. The indirect-jump pointer keeps its high-byte fetch in the same page as its low byte. A parameter selects the alternative carrying form of that fetch.

Top module: `eff_addr_unit`

## Requirements
- R1: Mode codes on `mode` are: 0 immediate, 1 zero page, 2 zero page + X, 3 zero page + Y, 4 absolute, 5 absolute + X, 6 absolute + Y, 7 pre-indexed pointer (zp + X), 8 post-indexed pointer (zp pointer, then + Y), 9 indirect jump. `ea`, `pc_next`, `page_cross` and `dummy` are registered, load on the clock edge where `req` is 1, and read 0 after reset.
- R2: Immediate mode gives `ea = pc` and `pc_next = pc + 1`, wrapping at 16 bits.
- R3: Zero-page mode gives `ea = {8'h00, op_lo}` with `pc_next = pc + 1`. Absolute mode gives `ea = {op_hi, op_lo}` with `pc_next = pc + 2`. Immediate, zero-page, absolute and indirect-jump modes never request a dummy cycle.
- R4: Zero page + X / + Y give `ea = {8'h00, (op_lo + index) mod 256}` and always request a dummy cycle.
- R5: Absolute + X / + Y give `ea = {op_hi, op_lo} + index` as a full 16-bit sum that wraps at FFFF, with `pc_next = pc + 2`. `page_cross` is 1 when this sum's bits [15:8] differ from `op_hi`. `page_cross` is 0 in every mode other than 5, 6 and 8.
- R6: For reads (`is_write` = 0) in modes 5, 6 and 8, a dummy cycle is requested exactly when a page crossing occurs.
- R7: For stores and read-modify-writes (`is_write` = 1) in modes 5, 6 and 8, a dummy cycle is always requested.
- R8: Mode 7 drives `ptr_lo_addr = {8'h00, (op_lo + X) mod 256}` and `ptr_hi_addr = {8'h00, (op_lo + X + 1) mod 256}`. It gives `ea = {ptr_hi, ptr_lo}`, `pc_next = pc + 1` and always a dummy cycle.
- R9: Mode 8 drives `ptr_lo_addr = {8'h00, op_lo}` and `ptr_hi_addr = {8'h00, (op_lo + 1) mod 256}`. It gives `ea = {ptr_hi, ptr_lo} + Y` as a 16-bit sum, and `page_cross` when that sum's high byte differs from `ptr_hi`.
- R10: Mode 9 drives `ptr_lo_addr = {op_hi, op_lo}` and `ptr_hi_addr = {op_hi, (op_lo + 1) mod 256}`, so a pointer at xxFF takes its high byte from xx00. It gives `ea = {ptr_hi, ptr_lo}` and `pc_next = pc + 2`.
- R11: `dummy` is a single-clock pulse. It is 0 in any clock that does not directly follow a `req` clock.
- R12: In modes 0 to 6, `ptr_lo_addr` and `ptr_hi_addr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Compute an address from the current inputs |
| mode | input | 4 | Addressing mode code (R1) |
| is_write | input | 1 | 1 for store or read-modify-write, 0 for read |
| pc | input | 16 | Program counter pointing at the first operand byte |
| op_lo | input | 8 | First operand byte |
| op_hi | input | 8 | Second operand byte |
| idx_x | input | 8 | X index register |
| idx_y | input | 8 | Y index register |
| ptr_lo | input | 8 | Pointer low byte read from memory |
| ptr_hi | input | 8 | Pointer high byte read from memory |
| ptr_lo_addr | output | 16 | Address for the pointer low-byte fetch |
| ptr_hi_addr | output | 16 | Address for the pointer high-byte fetch |
| ea | output | 16 | Effective address |
| pc_next | output | 16 | Program counter after the operand bytes |
| page_cross | output | 1 | Indexing changed the high address byte |
| dummy | output | 1 | One-clock request for an extra bus cycle |

## Verification
The hardest situations to reach are those where the carry out of the low byte must be kept or discarded depending on the mode. These are a zero-page pointer at FF and an indirect-jump pointer at xxFF, where the carry must be discarded. The other is a post-indexed sum that wraps past FFFF, where it must be kept. The stimulus places operand bytes at exactly those boundaries and checks the pointer fetch addresses combinationally in the same clock. For the cost logic, the vectors pair each indexed mode with read and write accesses, both with and without a crossing, so the two penalty rules are separated.

// File: rtl/eau_pkg.sv
package eau_pkg;

   localparam int MODE_W = 4;

   typedef enum logic [MODE_W-1:0] {
      AM_IMM = 4'd0,
      AM_ZP  = 4'd1,
      AM_ZPX = 4'd2,
      AM_ZPY = 4'd3,
      AM_ABS = 4'd4,
      AM_ABX = 4'd5,
      AM_ABY = 4'd6,
      AM_IZX = 4'd7,
      AM_IZY = 4'd8,
      AM_IND = 4'd9
   } am_t;

   // modes whose indexing may cross a page
   function automatic logic am_page_sensitive(am_t m);
      return (m == AM_ABX) || (m == AM_ABY) || (m == AM_IZY);
   endfunction

   // modes that stay in page zero with a fixed extra cycle
   function automatic logic am_zp_indexed(am_t m);
      return (m == AM_ZPX) || (m == AM_ZPY);
   endfunction

endpackage

// File: rtl/eau_index_add.sv
module eau_index_add #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [DATA_W-1:0] idx,
   output logic [ADDR_W-1:0] sum,
   output logic              crossed
);
   localparam int HI_W = ADDR_W - DATA_W;

   generate
      if (HI_W < 1) begin : g_bad_width
         $error("eau_index_add: ADDR_W must exceed DATA_W");
      end
   endgenerate

   always_comb begin
      sum     = base + {{HI_W{1'b0}}, idx};
      crossed = (sum[ADDR_W-1:DATA_W] != base[ADDR_W-1:DATA_W]);
   end

endmodule

// File: rtl/eau_ptr_gen.sv
module eau_ptr_gen
   import eau_pkg::*;
#(
   parameter int ADDR_W        = 16,
   parameter int DATA_W        = 8,
   parameter bit JMP_PAGE_WRAP = 1'b1
) (
   input  am_t               mode,
   input  logic [DATA_W-1:0] op_lo,
   input  logic [DATA_W-1:0] op_hi,
   input  logic [DATA_W-1:0] idx_x,
   output logic [ADDR_W-1:0] lo_addr,
   output logic [ADDR_W-1:0] hi_addr
);
   localparam int HI_W = ADDR_W - DATA_W;
   localparam logic [HI_W-1:0] PAGE0 = '0;

   logic [DATA_W-1:0] zp_pre;
   logic [DATA_W-1:0] zp_pre_nx;
   logic [DATA_W-1:0] zp_post_nx;
   logic [ADDR_W-1:0] jmp_lo;
   logic [ADDR_W-1:0] jmp_hi;

   always_comb begin
      zp_pre     = op_lo + idx_x;
      zp_pre_nx  = zp_pre + 1'b1;
      zp_post_nx = op_lo + 1'b1;
      jmp_lo     = {op_hi[HI_W-1:0], op_lo};
   end

   // high-byte fetch of the jump pointer: stay in page, or carry
   generate
      if (JMP_PAGE_WRAP) begin : g_jmp_wrap
         assign jmp_hi = {op_hi[HI_W-1:0], zp_post_nx};
      end else begin : g_jmp_carry
         assign jmp_hi = jmp_lo + 1'b1;
      end
   endgenerate

   always_comb begin
      lo_addr = '0;
      hi_addr = '0;
      unique case (mode)
         AM_IZX: begin
            lo_addr = {PAGE0, zp_pre};
            hi_addr = {PAGE0, zp_pre_nx};
         end
         AM_IZY: begin
            lo_addr = {PAGE0, op_lo};
            hi_addr = {PAGE0, zp_post_nx};
         end
         AM_IND: begin
            lo_addr = jmp_lo;
            hi_addr = jmp_hi;
         end
         default: ;
      endcase
   end

   // pointer fetches of the zero-page pointer modes never leave page zero
   always_comb begin
      if (mode == AM_IZX || mode == AM_IZY) begin
         assert_ptr_page0_R8: assert (lo_addr[ADDR_W-1:DATA_W] == '0 &&
                                      hi_addr[ADDR_W-1:DATA_W] == '0);
      end
   end

   // both halves of the jump pointer come from one page in the wrapping form
   always_comb begin
      if (JMP_PAGE_WRAP && mode == AM_IND) begin
         assert_jmp_same_page_R10: assert (lo_addr[ADDR_W-1:DATA_W] ==
                                           hi_addr[ADDR_W-1:DATA_W]);
      end
   end

endmodule

// File: rtl/eau_cost.sv
module eau_cost
   import eau_pkg::*;
(
   input  am_t  mode,
   input  logic is_write,
   input  logic crossed,
   output logic penalty,
   output logic pc_two
);
   always_comb begin
      penalty = 1'b0;
      if (am_zp_indexed(mode) || mode == AM_IZX) begin
         penalty = 1'b1;
      end else if (am_page_sensitive(mode)) begin
         penalty = is_write | crossed;
      end
      pc_two = (mode == AM_ABS) || (mode == AM_ABX) ||
               (mode == AM_ABY) || (mode == AM_IND);
   end

   // a read with no crossing in a page-sensitive mode costs nothing extra
   always_comb begin
      if (am_page_sensitive(mode) && !is_write && !crossed) begin
         assert_read_no_cross_R6: assert (!penalty);
      end
   end

endmodule

// File: rtl/eff_addr_unit.sv
module eff_addr_unit
   import eau_pkg::*;
#(
   parameter int ADDR_W        = 16,
   parameter int DATA_W        = 8,
   parameter bit JMP_PAGE_WRAP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic [3:0]        mode,
   input  logic              is_write,
   input  logic [ADDR_W-1:0] pc,
   input  logic [DATA_W-1:0] op_lo,
   input  logic [DATA_W-1:0] op_hi,
   input  logic [DATA_W-1:0] idx_x,
   input  logic [DATA_W-1:0] idx_y,
   input  logic [DATA_W-1:0] ptr_lo,
   input  logic [DATA_W-1:0] ptr_hi,
   output logic [ADDR_W-1:0] ptr_lo_addr,
   output logic [ADDR_W-1:0] ptr_hi_addr,
   output logic [ADDR_W-1:0] ea,
   output logic [ADDR_W-1:0] pc_next,
   output logic              page_cross,
   output logic              dummy
);
   localparam int HI_W  = ADDR_W - DATA_W;
   localparam int LANES = 2;          // 0: operand base, 1: pointer base
   localparam int L_ABS = 0;
   localparam int L_PTR = 1;
   localparam logic [HI_W-1:0] PAGE0 = '0;

   generate
      if (ADDR_W != 2 * DATA_W) begin : g_bad_geom
         $error("eff_addr_unit: ADDR_W must be twice DATA_W");
      end
      if (MODE_W != 4) begin : g_bad_mode
         $error("eff_addr_unit: mode port is 4 bits wide");
      end
   endgenerate

   am_t m;
   assign m = am_t'(mode);

   // ---------------- indexed adders ----------------
   logic [ADDR_W-1:0] lane_base [LANES];
   logic [DATA_W-1:0] lane_idx  [LANES];
   logic [ADDR_W-1:0] lane_sum  [LANES];
   logic              lane_x    [LANES];

   always_comb begin
      lane_base[L_ABS] = {op_hi[HI_W-1:0], op_lo};
      lane_idx[L_ABS]  = (m == AM_ABX) ? idx_x : idx_y;
      lane_base[L_PTR] = {ptr_hi[HI_W-1:0], ptr_lo};
      lane_idx[L_PTR]  = idx_y;
   end

   genvar g;
   generate
      for (g = 0; g < LANES; g++) begin : g_lane
         eau_index_add #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_add (
            .base    (lane_base[g]),
            .idx     (lane_idx[g]),
            .sum     (lane_sum[g]),
            .crossed (lane_x[g])
         );
      end
   endgenerate

   // ---------------- pointer fetch addresses ----------------
   eau_ptr_gen #(
      .ADDR_W        (ADDR_W),
      .DATA_W        (DATA_W),
      .JMP_PAGE_WRAP (JMP_PAGE_WRAP)
   ) u_ptr (
      .mode    (m),
      .op_lo   (op_lo),
      .op_hi   (op_hi),
      .idx_x   (idx_x),
      .lo_addr (ptr_lo_addr),
      .hi_addr (ptr_hi_addr)
   );

   // ---------------- address selection ----------------
   logic [DATA_W-1:0] zp_off;
   logic [ADDR_W-1:0] ea_d;
   logic              cross_d;

   always_comb begin
      zp_off  = op_lo + ((m == AM_ZPY) ? idx_y : idx_x);
      ea_d    = '0;
      cross_d = 1'b0;
      unique case (m)
         AM_IMM:         ea_d = pc;
         AM_ZP:          ea_d = {PAGE0, op_lo};
         AM_ZPX, AM_ZPY: ea_d = {PAGE0, zp_off};
         AM_ABS:         ea_d = lane_base[L_ABS];
         AM_ABX, AM_ABY: begin
            ea_d    = lane_sum[L_ABS];
            cross_d = lane_x[L_ABS];
         end
         AM_IZX, AM_IND: ea_d = lane_base[L_PTR];
         AM_IZY: begin
            ea_d    = lane_sum[L_PTR];
            cross_d = lane_x[L_PTR];
         end
         default: ;
      endcase
   end

   // ---------------- cycle cost ----------------
   logic penalty_d;
   logic pc_two;

   eau_cost u_cost (
      .mode     (m),
      .is_write (is_write),
      .crossed  (cross_d),
      .penalty  (penalty_d),
      .pc_two   (pc_two)
   );

   logic [ADDR_W-1:0] pc_d;
   assign pc_d = pc + (pc_two ? ADDR_W'(2) : ADDR_W'(1));

   // ---------------- result registers ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ea         <= '0;
         pc_next    <= '0;
         page_cross <= 1'b0;
         dummy      <= 1'b0;
      end else begin
         dummy <= req & penalty_d;
         if (req) begin
            ea         <= ea_d;
            pc_next    <= pc_d;
            page_cross <= cross_d;
         end
      end
   end

   // ---------------- protocol checks ----------------
   assert_pulse_after_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
      dummy |-> $past(req));

   assert_zp_indexed_R4: assert property (@(posedge clk) disable iff (!rst_n)
      req && (mode == AM_ZPX || mode == AM_ZPY)
      |=> dummy && ea[ADDR_W-1:DATA_W] == '0);

   assert_write_penalty_R7: assert property (@(posedge clk) disable iff (!rst_n)
      req && is_write && (mode == AM_ABX || mode == AM_ABY || mode == AM_IZY)
      |=> dummy);

   assert_free_modes_R3: assert property (@(posedge clk) disable iff (!rst_n)
      req && (mode == AM_IMM || mode == AM_ZP || mode == AM_ABS || mode == AM_IND)
      |=> !dummy && !page_cross);

   assert_imm_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      req && mode == AM_IMM |=> pc_next == $past(pc) + 1'b1 && ea == $past(pc));

   assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !req |=> $stable(ea) && $stable(pc_next));

endmodule

// File: tb/eff_addr_unit_tb.sv
`timescale 1ns/1ps
module eff_addr_unit_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0;
   logic [3:0]  mode = '0;
   logic        is_write = 1'b0;
   logic [15:0] pc = '0;
   logic [7:0]  op_lo = '0, op_hi = '0, idx_x = '0, idx_y = '0;
   logic [7:0]  ptr_lo = '0, ptr_hi = '0;
   logic [15:0] ptr_lo_addr, ptr_hi_addr, ea, pc_next;
   logic        page_cross, dummy;

   int checks = 0;
   int failures = 0;

   always #10 clk = ~clk;   // 50 MHz

   eff_addr_unit u_dut (
      .clk(clk), .rst_n(rst_n), .req(req), .mode(mode), .is_write(is_write),
      .pc(pc), .op_lo(op_lo), .op_hi(op_hi), .idx_x(idx_x), .idx_y(idx_y),
      .ptr_lo(ptr_lo), .ptr_hi(ptr_hi), .ptr_lo_addr(ptr_lo_addr),
      .ptr_hi_addr(ptr_hi_addr), .ea(ea), .pc_next(pc_next),
      .page_cross(page_cross), .dummy(dummy)
   );

   typedef struct packed {
      logic [3:0]  m;
      logic        w;
      logic [15:0] pc;
      logic [7:0]  lo, hi, x, y, plo, phi;
      logic [15:0] e_ea, e_pc;
      logic        e_d, e_c;
   } vec_t;

   localparam int NV = 16;
   localparam vec_t VEC [NV] = '{
      '{4'd0, 1'b0, 16'h1234, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 16'h1234, 16'h1235, 1'b0, 1'b0},
      '{4'd0, 1'b0, 16'hFFFF, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 16'hFFFF, 16'h0000, 1'b0, 1'b0},
      '{4'd1, 1'b0, 16'h0200, 8'h80, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 16'h0080, 16'h0201, 1'b0, 1'b0},
      '{4'd2, 1'b0, 16'h0200, 8'hF0, 8'h00, 8'h20, 8'h00, 8'h00, 8'h00, 16'h0010, 16'h0201, 1'b1, 1'b0},
      '{4'd3, 1'b1, 16'h0200, 8'h10, 8'h00, 8'h00, 8'h05, 8'h00, 8'h00, 16'h0015, 16'h0201, 1'b1, 1'b0},
      '{4'd4, 1'b0, 16'h0300, 8'h34, 8'h12, 8'h00, 8'h00, 8'h00, 8'h00, 16'h1234, 16'h0302, 1'b0, 1'b0},
      '{4'd5, 1'b0, 16'h0300, 8'hF0, 8'h12, 8'h05, 8'h00, 8'h00, 8'h00, 16'h12F5, 16'h0302, 1'b0, 1'b0},
      '{4'd5, 1'b0, 16'h0300, 8'hF0, 8'h12, 8'h20, 8'h00, 8'h00, 8'h00, 16'h1310, 16'h0302, 1'b1, 1'b1},
      '{4'd5, 1'b1, 16'h0300, 8'h00, 8'h12, 8'h01, 8'h00, 8'h00, 8'h00, 16'h1201, 16'h0302, 1'b1, 1'b0},
      '{4'd6, 1'b0, 16'h0300, 8'hFF, 8'hFF, 8'h00, 8'h01, 8'h00, 8'h00, 16'h0000, 16'h0302, 1'b1, 1'b1},
      '{4'd6, 1'b1, 16'h0300, 8'h80, 8'h40, 8'h00, 8'h90, 8'h00, 8'h00, 16'h4110, 16'h0302, 1'b1, 1'b1},
      '{4'd7, 1'b0, 16'h0500, 8'h40, 8'h00, 8'h10, 8'h00, 8'h78, 8'h56, 16'h5678, 16'h0501, 1'b1, 1'b0},
      '{4'd8, 1'b0, 16'h0500, 8'h40, 8'h00, 8'h00, 8'h10, 8'hF0, 8'h20, 16'h2100, 16'h0501, 1'b1, 1'b1},
      '{4'd8, 1'b0, 16'h0500, 8'h40, 8'h00, 8'h00, 8'h10, 8'h10, 8'h20, 16'h2020, 16'h0501, 1'b0, 1'b0},
      '{4'd8, 1'b1, 16'h0500, 8'h40, 8'h00, 8'h00, 8'h10, 8'h10, 8'h20, 16'h2020, 16'h0501, 1'b1, 1'b0},
      '{4'd9, 1'b0, 16'h0400, 8'hFF, 8'h30, 8'h00, 8'h00, 8'hCD, 8'hAB, 16'hABCD, 16'h0402, 1'b0, 1'b0}
   };

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   function automatic string tag_of(input logic [3:0] m, input logic w);
      case (m)
         4'd0: return "R2";
         4'd1, 4'd4: return "R3";
         4'd2, 4'd3: return "R4";
         4'd5, 4'd6: return w ? "R7" : "R5/R6";
         4'd7: return "R8";
         4'd8: return w ? "R7" : "R9";
         default: return "R10";
      endcase
   endfunction

   task automatic drive(input vec_t v);
      mode = v.m; is_write = v.w; pc = v.pc; op_lo = v.lo; op_hi = v.hi;
      idx_x = v.x; idx_y = v.y; ptr_lo = v.plo; ptr_hi = v.phi;
   endtask

   task automatic run_vec(input vec_t v);
      string t;
      t = tag_of(v.m, v.w);
      @(negedge clk);
      drive(v);
      req = 1'b1;
      @(negedge clk);
      req = 1'b0;
      check(ea == v.e_ea, t, "ea", 32'(ea), 32'(v.e_ea));
      check(pc_next == v.e_pc, t, "pc_next", 32'(pc_next), 32'(v.e_pc));
      check(dummy == v.e_d, t, "dummy", 32'(dummy), 32'(v.e_d));
      check(page_cross == v.e_c, t, "page_cross", 32'(page_cross), 32'(v.e_c));
   endtask

   task automatic ptr_probe(input logic [3:0] m, input logic [7:0] lo, input logic [7:0] hi,
                            input logic [7:0] x, input logic [15:0] e_lo,
                            input logic [15:0] e_hi, input string t);
      @(negedge clk);
      mode = m; op_lo = lo; op_hi = hi; idx_x = x;
      #1;
      check(ptr_lo_addr == e_lo, t, "ptr_lo_addr", 32'(ptr_lo_addr), 32'(e_lo));
      check(ptr_hi_addr == e_hi, t, "ptr_hi_addr", 32'(ptr_hi_addr), 32'(e_hi));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check(ea == 16'h0, "R1", "reset ea", 32'(ea), 32'h0);
      check(pc_next == 16'h0, "R1", "reset pc_next", 32'(pc_next), 32'h0);
      check(dummy == 1'b0, "R1", "reset dummy", 32'(dummy), 32'h0);
      check(page_cross == 1'b0, "R1", "reset page_cross", 32'(page_cross), 32'h0);

      for (int i = 0; i < NV; i++) begin
         run_vec(VEC[i]);
      end

      // R11: pulse drops one clock after a penalised request (last zp+X case)
      run_vec(VEC[3]);
      @(negedge clk);
      check(dummy == 1'b0, "R11", "dummy after pulse", 32'(dummy), 32'h0);
      // R1: outputs hold without req, even though inputs changed
      drive(VEC[5]);
      @(negedge clk);
      check(ea == 16'h0010, "R1", "ea hold", 32'(ea), 32'h0010);

      // R8: pointer fetch wraps in page zero
      ptr_probe(4'd7, 8'hFF, 8'h55, 8'h01, 16'h0000, 16'h0001, "R8");
      ptr_probe(4'd7, 8'hF0, 8'h55, 8'h0F, 16'h00FF, 16'h0000, "R8");
      // R9: pointer at FF takes high byte from 00
      ptr_probe(4'd8, 8'hFF, 8'h55, 8'h33, 16'h00FF, 16'h0000, "R9");
      // R10: jump pointer stays in its page
      ptr_probe(4'd9, 8'hFF, 8'h30, 8'h33, 16'h30FF, 16'h3000, "R10");
      ptr_probe(4'd9, 8'h10, 8'h30, 8'h00, 16'h3010, 16'h3011, "R10");
      // R12: no pointer addresses in direct modes
      ptr_probe(4'd5, 8'hFF, 8'h30, 8'h01, 16'h0000, 16'h0000, "R12");

      // R9: post-indexed sum wraps past FFFF
      run_vec('{4'd8, 1'b0, 16'h0600, 8'h20, 8'h00, 8'h00, 8'h02, 8'hFF, 8'hFF,
                16'h0001, 16'h0601, 1'b1, 1'b1});

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule